// File: doc/BRIEF.md
# Low-Power SDRAM Clock-Enable State Tracker

This block sits beside a memory controller and follows the power state of a low-power SDRAM by watching two things on every rising clock edge: the clock-enable level the controller drives, and the decoded command code it drives with it. Every decision uses the clock-enable level from the previous edge and the level at the present edge, together with the tracked state and the command. From these the block follows the device through not-initialised, idle, reading/writing, power-down, self refresh, the timed self-refresh exit window, clock suspend and deep power-down.

The tracker shows its state as a 3-bit code. It raises a ready strobe only when the device would accept a normal command, and it pulses an error flag for one cycle on each edge that carries a forbidden combination. One command code has two meanings. With clock enable high on both edges it is a plain burst terminate. With clock enable falling in idle it requests deep power-down. Leaving self refresh opens an exit window of programmable length, and only no-operation commands may appear inside it. Leaving deep power-down sends the tracker back to the not-initialised state and raises an initialisation request.

Command codes are: NOP=0, INHIBIT=1, ACTIVATE=2, READ=3, WRITE=4, BURST_TERM=5, AUTO_REFRESH=6, PRECHARGE=7. State codes are: UNINIT=0, IDLE=1, RW=2, PDOWN=3, SREF=4, SUSP=5, DPD=6, SRX=7. "Quiet" means NOP or INHIBIT. A pair is written as (previous level, present level), with H for high and L for low.

Top module: `cke_power_tracker`

## Requirements
- R1: A synchronous active-high reset sets the state to UNINIT (0), clears the error flag and the ready strobe, raises the initialisation request, and takes the previous clock-enable level as low.
- R2: In UNINIT, PRECHARGE (7) with clock enable high at the present edge moves to IDLE (1). Every other combination keeps UNINIT and raises no error.
- R3: With pair HH, ACTIVATE, READ or WRITE in IDLE moves to RW (2). PRECHARGE in RW moves to IDLE. AUTO_REFRESH in RW is an error. Every other command keeps the state.
- R4: In IDLE with pair HL, a quiet command enters PDOWN (3), AUTO_REFRESH enters SREF (4) and BURST_TERM (5) enters DPD (6). Any other command is an error.
- R5: In RW with pair HL, the tracker enters SUSP (5) whatever the command.
- R6: In PDOWN, SREF, SUSP or DPD with pair LL, the state holds and no error is raised, whatever the command.
- R7: In PDOWN with pair LH, a quiet command returns to IDLE, and ready is high from that edge on. Any other command is an error.
- R8: In SUSP with pair LH, the tracker resumes RW whatever the command, and ready is high from that edge on.
- R9: In SREF with pair LH, a quiet command enters SRX (7) and opens a window of W = max(exit_cycles, 2) edges, with exit_cycles sampled at the exit edge. The W-th following edge with clock enable high moves to IDLE. A non-quiet command, or clock enable low, on an edge inside the window is an error.
- R10: With pair HH, BURST_TERM never enters DPD. It keeps IDLE or RW.
- R11: In DPD with pair LH, the tracker moves to UNINIT whatever the command, and the initialisation request goes high.
- R12: Any combination not listed above raises the error flag for exactly the cycle after that edge, and the state holds.
- R13: Ready is high only in IDLE or RW. It is low in every low-power state, in the exit window and in UNINIT. The initialisation request is high only in UNINIT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every decision is taken on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cke | input | 1 | Clock-enable level driven to the device |
| cmd | input | 3 | Decoded command code at this edge |
| exit_cycles | input | CNT_W | Requested self-refresh exit window length in edges |
| state_o | output | 3 | Tracked power state code |
| ready_o | output | 1 | High when a normal command may be issued |
| err_o | output | 1 | One-cycle pulse after an illegal edge |
| init_req_o | output | 1 | High while a full initialisation is required |

## Verification
The bound checker watches four rules on every cycle. A low-power state holds without error while clock enable stays low. A falling edge in RW always enters suspend. Deep power-down is entered only on a falling edge. Leaving deep power-down raises the initialisation request. The checker also confirms that ready stays low inside the exit window. The length of the self-refresh exit window, the error raised by a non-quiet command inside it, the double meaning of the burst-terminate code and the illegal-combination pulses depend on command sequences. Only the bench's directed scenarios and its random run, compared edge by edge against a reference model, can show those.

// File: rtl/cke_tracker_pkg.sv
package cke_tracker_pkg;

    typedef enum logic [2:0] {
        ST_UNINIT = 3'd0,
        ST_IDLE   = 3'd1,
        ST_RW     = 3'd2,
        ST_PDOWN  = 3'd3,
        ST_SREF   = 3'd4,
        ST_SUSP   = 3'd5,
        ST_DPD    = 3'd6,
        ST_SRX    = 3'd7
    } pwr_state_t;

    typedef enum logic [2:0] {
        CM_NOP   = 3'd0,
        CM_INH   = 3'd1,
        CM_ACT   = 3'd2,
        CM_RD    = 3'd3,
        CM_WR    = 3'd4,
        CM_BT    = 3'd5,
        CM_AREF  = 3'd6,
        CM_PRE   = 3'd7
    } mem_cmd_t;

    localparam int unsigned MIN_EXIT_EDGES = 2;

    function automatic logic is_quiet(input mem_cmd_t c);
        return (c == CM_NOP) || (c == CM_INH);
    endfunction

    function automatic logic is_lowpower(input pwr_state_t s);
        return (s == ST_PDOWN) || (s == ST_SREF) || (s == ST_SUSP) || (s == ST_DPD);
    endfunction

endpackage

// File: rtl/cke_history.sv
module cke_history (
    input  logic clk,
    input  logic rst,
    input  logic cke,
    output logic cke_prev
);
    always_ff @(posedge clk) begin
        if (rst) cke_prev <= 1'b0;
        else     cke_prev <= cke;
    end
endmodule

// File: rtl/exit_window.sv
module exit_window #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    output logic             last
);
    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (rst)
            remain_q <= '0;
        else if (load)
            remain_q <= load_val;
        else if (step && remain_q != '0)
            remain_q <= remain_q - 1'b1;
    end

    assign last = (remain_q == CNT_W'(1));
endmodule

// File: rtl/trans_decode.sv
module trans_decode
    import cke_tracker_pkg::*;
(
    input  pwr_state_t cur_state,
    input  logic       cke_prev,
    input  logic       cke_now,
    input  mem_cmd_t   cmd,
    input  logic       win_last,
    output pwr_state_t nxt_state,
    output logic       illegal,
    output logic       win_load,
    output logic       win_step
);
    logic hh, hl, ll, lh;

    always_comb begin
        hh = cke_prev & cke_now;
        hl = cke_prev & ~cke_now;
        ll = ~cke_prev & ~cke_now;
        lh = ~cke_prev & cke_now;
        nxt_state = cur_state;
        illegal   = 1'b0;
        win_load  = 1'b0;
        win_step  = 1'b0;
        unique case (cur_state)
            ST_UNINIT: begin
                if (cke_now && cmd == CM_PRE) nxt_state = ST_IDLE;
            end
            ST_IDLE: begin
                if (hh) begin
                    if (cmd == CM_ACT || cmd == CM_RD || cmd == CM_WR) nxt_state = ST_RW;
                end else if (hl) begin
                    if (is_quiet(cmd))        nxt_state = ST_PDOWN;
                    else if (cmd == CM_AREF)  nxt_state = ST_SREF;
                    else if (cmd == CM_BT)    nxt_state = ST_DPD;
                    else                      illegal   = 1'b1;
                end else begin
                    illegal = 1'b1;
                end
            end
            ST_RW: begin
                if (hh) begin
                    if (cmd == CM_PRE)       nxt_state = ST_IDLE;
                    else if (cmd == CM_AREF) illegal   = 1'b1;
                end else if (hl) begin
                    nxt_state = ST_SUSP;
                end else begin
                    illegal = 1'b1;
                end
            end
            ST_PDOWN, ST_SREF, ST_SUSP, ST_DPD: begin
                if (lh) begin
                    unique case (cur_state)
                        ST_PDOWN: if (is_quiet(cmd)) nxt_state = ST_IDLE; else illegal = 1'b1;
                        ST_SREF: begin
                            if (is_quiet(cmd)) begin
                                nxt_state = ST_SRX;
                                win_load  = 1'b1;
                            end else begin
                                illegal = 1'b1;
                            end
                        end
                        ST_SUSP: nxt_state = ST_RW;
                        default: nxt_state = ST_UNINIT;
                    endcase
                end else if (!ll) begin
                    illegal = 1'b1;
                end
            end
            ST_SRX: begin
                if (!cke_now) begin
                    illegal = 1'b1;
                end else begin
                    win_step = 1'b1;
                    if (!is_quiet(cmd)) illegal = 1'b1;
                    if (win_last) nxt_state = ST_IDLE;
                end
            end
            default: nxt_state = ST_UNINIT;
        endcase
    end
endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
    import cke_tracker_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cke,
    input  logic [2:0]       cmd,
    input  logic [CNT_W-1:0] exit_cycles,
    output logic [2:0]       state_o,
    output logic             ready_o,
    output logic             err_o,
    output logic             init_req_o
);
    localparam logic [CNT_W-1:0] MIN_WIN = CNT_W'(MIN_EXIT_EDGES);

    pwr_state_t       state_q, state_d;
    logic             cke_prev, illegal, win_load, win_step, win_last, err_q;
    logic [CNT_W-1:0] win_len;

    assign win_len = (exit_cycles < MIN_WIN) ? MIN_WIN : exit_cycles;

    cke_history u_hist (
        .clk      (clk),
        .rst      (rst),
        .cke      (cke),
        .cke_prev (cke_prev)
    );

    trans_decode u_dec (
        .cur_state (state_q),
        .cke_prev  (cke_prev),
        .cke_now   (cke),
        .cmd       (mem_cmd_t'(cmd)),
        .win_last  (win_last),
        .nxt_state (state_d),
        .illegal   (illegal),
        .win_load  (win_load),
        .win_step  (win_step)
    );

    exit_window #(.CNT_W(CNT_W)) u_win (
        .clk      (clk),
        .rst      (rst),
        .load     (win_load),
        .load_val (win_len),
        .step     (win_step),
        .last     (win_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_UNINIT;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= illegal;
        end
    end

    assign state_o    = state_q;
    assign err_o      = err_q;
    assign ready_o    = (state_q == ST_IDLE) || (state_q == ST_RW);
    assign init_req_o = (state_q == ST_UNINIT);
endmodule

// File: rtl/cke_power_tracker_checker.sv
module cke_power_tracker_checker
    import cke_tracker_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cke,
    input logic [2:0] state_o,
    input logic       ready_o,
    input logic       err_o,
    input logic       init_req_o
);
    pwr_state_t st;
    assign st = pwr_state_t'(state_o);

    AST_LOWPWR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (is_lowpower(st) && !$past(cke) && !cke) |=> ($stable(state_o) && !err_o)); // R6

    AST_SUSPEND_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RW && $past(cke) && !cke) |=> (pwr_state_t'(state_o) == ST_SUSP)); // R5

    AST_DPD_ON_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (st != ST_DPD && !($past(cke) && !cke)) |=> (pwr_state_t'(state_o) != ST_DPD)); // R10

    AST_DPD_EXIT_INIT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DPD && !$past(cke) && cke) |=> init_req_o); // R11

    AST_WINDOW_NOT_READY: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SRX) |-> !ready_o); // R13
endmodule

bind cke_power_tracker cke_power_tracker_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cke        (cke),
    .state_o    (state_o),
    .ready_o    (ready_o),
    .err_o      (err_o),
    .init_req_o (init_req_o)
);

// File: tb/cke_power_tracker_test.sv
module cke_power_tracker_test;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    localparam logic [2:0] S_UN = 0, S_ID = 1, S_RW = 2, S_PD = 3,
                           S_SR = 4, S_SU = 5, S_DP = 6, S_SX = 7;
    localparam logic [2:0] C_NOP = 0, C_INH = 1, C_ACT = 2, C_RD = 3,
                           C_WR = 4, C_BT = 5, C_AREF = 6, C_PRE = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cke = 1'b0;
    logic [2:0]    cmd = C_NOP;
    logic [CW-1:0] exit_cycles = '0;
    logic [2:0]    state_o;
    logic          ready_o, err_o, init_req_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    logic [2:0]    m_st;
    logic          m_prev, m_err;
    int            m_cnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    cke_power_tracker #(.CNT_W(CW)) uut (
        .clk(clk), .rst(rst), .cke(cke), .cmd(cmd), .exit_cycles(exit_cycles),
        .state_o(state_o), .ready_o(ready_o), .err_o(err_o), .init_req_o(init_req_o)
    );

    function automatic bit quiet(input logic [2:0] c);
        return c == C_NOP || c == C_INH;
    endfunction

    // reference model: one rising edge
    task automatic model_edge(input logic k, input logic [2:0] c);
        logic [2:0] ns = m_st;
        bit bad = 0;
        int len = (int'(exit_cycles) < 2) ? 2 : int'(exit_cycles);
        case (m_st)
            S_UN: if (k && c == C_PRE) ns = S_ID;
            S_ID:
                if (m_prev && k) begin
                    if (c inside {C_ACT, C_RD, C_WR}) ns = S_RW;
                end else if (m_prev && !k) begin
                    if (quiet(c)) ns = S_PD;
                    else if (c == C_AREF) ns = S_SR;
                    else if (c == C_BT) ns = S_DP;
                    else bad = 1;
                end else bad = 1;
            S_RW:
                if (m_prev && k) begin
                    if (c == C_PRE) ns = S_ID;
                    else if (c == C_AREF) bad = 1;
                end else if (m_prev && !k) ns = S_SU;
                else bad = 1;
            S_SX:
                if (!k) bad = 1;
                else begin
                    if (!quiet(c)) bad = 1;
                    if (m_cnt == 1) ns = S_ID;
                    if (m_cnt > 0) m_cnt--;
                end
            default:
                if (!m_prev && !k) ns = m_st;
                else if (!m_prev && k) begin
                    if (m_st == S_PD) begin if (quiet(c)) ns = S_ID; else bad = 1; end
                    else if (m_st == S_SR) begin
                        if (quiet(c)) begin ns = S_SX; m_cnt = len; end else bad = 1;
                    end
                    else if (m_st == S_SU) ns = S_RW;
                    else ns = S_UN;
                end else bad = 1;
        endcase
        m_st = ns; m_err = bad; m_prev = k;
    endtask

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, "state", state_o, m_st);
        check(tag, "err", err_o, m_err);
        check("R13", "ready", ready_o, (m_st == S_ID || m_st == S_RW));
        check("R13", "init_req", init_req_o, (m_st == S_UN));
    endtask

    task automatic step(input logic k, input logic [2:0] c, input string tag);
        @(negedge clk);
        cke = k; cmd = c;
        @(posedge clk);
        model_edge(k, c);
        #1;
        compare_all(tag);
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; cke = 1'b0; cmd = C_NOP;
        repeat (3) @(posedge clk);
        #1;
        m_st = S_UN; m_prev = 0; m_err = 0; m_cnt = 0;
        compare_all("R1");
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        do_reset();
        // init and power-down
        step(1, C_NOP, "R2");  step(1, C_BT, "R2");  step(1, C_PRE, "R2");
        step(0, C_NOP, "R4");  step(0, C_RD, "R6");  step(1, C_INH, "R7");
        // active, burst terminate, suspend
        step(1, C_ACT, "R3");  step(1, C_BT, "R10"); step(1, C_AREF, "R3");
        step(0, C_WR, "R5");   step(0, C_PRE, "R6"); step(1, C_RD, "R8");
        step(1, C_PRE, "R3");  step(1, C_BT, "R10");
        // self refresh with minimum window
        exit_cycles = 0;
        step(0, C_AREF, "R4"); step(0, C_ACT, "R6"); step(1, C_NOP, "R9");
        step(1, C_NOP, "R9");  step(1, C_NOP, "R9");
        check("R9", "idle after min window", state_o, S_ID);
        // longer window with a violation inside
        exit_cycles = 5;
        step(0, C_AREF, "R4"); step(1, C_NOP, "R9"); exit_cycles = 1;
        step(1, C_NOP, "R9");  step(1, C_ACT, "R9");
        check("R9", "err in window", err_o, 1);
        for (int i = 0; i < 3; i++) step(1, C_NOP, "R9");
        check("R9", "idle after 5 edges", state_o, S_ID);
        // deep power-down round trip
        step(0, C_BT, "R4");   step(0, C_WR, "R6");  step(1, C_ACT, "R11");
        check("R11", "init request", init_req_o, 1);
        step(1, C_PRE, "R2");
        // illegal combinations
        step(0, C_ACT, "R12"); step(0, C_NOP, "R12"); step(1, C_NOP, "R12");
        step(1, C_NOP, "R12");
        step(0, C_NOP, "R4");  step(0, C_NOP, "R6"); step(1, C_ACT, "R7");
        step(1, C_NOP, "R12");
        // reset from a busy state
        step(1, C_ACT, "R3");
        do_reset();
        // constrained random run
        for (int i = 0; i < 3000; i++) begin
            logic k = cke;
            logic [2:0] c;
            if ($urandom_range(7) == 0) k = ~k;
            c = ($urandom_range(1) == 0) ? C_NOP : 3'($urandom_range(7));
            if ($urandom_range(63) == 0) exit_cycles = CW'($urandom_range(6));
            step(k, c, "R12");
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule